// File: doc/BRIEF.md
# Strobe-Triggered Parallel Word Transfer Controller

This block moves 16-bit words between an external device and two banks of 32 words inside the chip. The device supplies a direction line, a slow transfer strobe and a 5-bit word address. When the direction line is low, the device is the source. On each strobe edge, the block stores the word the device presents into the receive bank. When the direction line is high, the device is the sink. On each strobe edge, the block fetches the addressed word from the transmit bank and presents it on the shared data pins, which it drives only while the direction line is high.

The strobe is not a clock. Every external input goes through a two-stage synchronizer in the system clock domain. Both edges of the strobe are detected by comparing the synchronized strobe with a copy one cycle older. On-chip logic fills the transmit bank through a simple write port and reads the receive bank through a combinational read port. The pin-level tristate buffer is modelled as a data-out bus plus a drive-enable output.

Top module: `strobe_xfer_ctrl`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it falls, `ext_data_oe` is 0 and `ext_data_out` is 0. Reset clears every word of both banks to 0.
- R2: `ext_data_oe` follows `ext_dir` three rising clock edges after an input change: two synchronizer stages plus one state register. This holds for both rising and falling changes. It is 0 for the first three clock edges after reset.
- R3: With `ext_dir` low, each strobe edge, rising or falling, stores `ext_data_in` into receive word `ext_addr`. Inputs that are stable before edge k1 are written at edge k3, where k1 is the first clock edge that samples the new strobe level.
- R4: With `ext_dir` high, each strobe edge loads transmit word `ext_addr` into `ext_data_out` at edge k3. `ext_data_out` holds that value until the next outbound strobe edge.
- R5: A strobe held at a constant level triggers no transfer. Changes on `ext_addr` or `ext_data_in` alone leave both the receive bank and `ext_data_out` unchanged.
- R6: A transfer takes its direction from `ext_dir` as synchronized alongside the strobe. An inbound transfer never changes `ext_data_out`. An outbound transfer never writes the receive bank.
- R7: If the strobe is high when reset is released, no transfer results. The first strobe change after the three-cycle warm-up triggers exactly one transfer.
- R8: A `tx_wr_en` pulse writes `tx_wr_data` into transmit word `tx_wr_addr` at that clock edge. `rx_rd_data` shows receive word `rx_rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the strobe |
| rst | input | 1 | Synchronous active-high reset |
| ext_dir | input | 1 | Transfer direction from the device: 0 inbound, 1 outbound |
| ext_strobe | input | 1 | Asynchronous transfer strobe; each edge moves one word |
| ext_addr | input | 5 | Word address driven by the device |
| ext_data_in | input | 16 | Input side of the shared data pins |
| ext_data_out | output | 16 | Output side of the shared data pins |
| ext_data_oe | output | 1 | Drive enable for the data pins |
| tx_wr_en | input | 1 | Transmit bank write strobe (on-chip side) |
| tx_wr_addr | input | 5 | Transmit bank write address |
| tx_wr_data | input | 16 | Transmit bank write word |
| rx_rd_addr | input | 5 | Receive bank read address |
| rx_rd_data | output | 16 | Receive bank read word |

## Verification
The bench sweeps all 32 addresses in both directions, alternating strobe polarity. A design that reacts to only one strobe edge therefore leaves every other word unwritten. It measures the drive-enable latency edge by edge in both directions, so an extra or missing pipeline stage shows up as an early or late flip. It releases reset with the strobe already high and checks that no word is written. A detector that is not cleared at reset would store a spurious word there. It also changes address and data with the strobe still, rewrites the transmit bank without a strobe edge, and reads the receive bank back after outbound traffic. These checks expose level-triggered transfers, a combinational data path to the pins, and transfers that take the wrong direction.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int unsigned XFER_DATA_W      = 16;
    localparam int unsigned XFER_ADDR_W      = 5;
    localparam int unsigned XFER_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        XS_WARMUP   = 2'd0,
        XS_INBOUND  = 2'd1,
        XS_OUTBOUND = 2'd2
    } xfer_state_e;

    // Cycles after reset during which edges are ignored: pipeline fill plus the delayed copy.
    function automatic int unsigned warmup_cycles(input int unsigned stages);
        return stages + 1;
    endfunction

endpackage

// File: rtl/xfer_sync.sv
module xfer_sync #(
    parameter int unsigned WIDTH  = 23,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xfer_bank.sv
module xfer_bank #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(WORDS); i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
    import xfer_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_s,
    input  logic              strobe_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output logic              rx_we,
    output logic [ADDR_W-1:0] rx_waddr,
    output logic [DATA_W-1:0] rx_wdata,
    output logic              tx_fetch,
    output logic [ADDR_W-1:0] tx_raddr,
    input  logic [DATA_W-1:0] tx_rdata,
    output logic [DATA_W-1:0] out_data,
    output logic              out_en
);
    localparam int unsigned WARM  = warmup_cycles(SYNC_STAGES);
    localparam int unsigned CNT_W = $clog2(WARM + 1);

    xfer_state_e       state_q, state_d;
    logic [CNT_W-1:0]  warm_q;
    logic              strobe_d1_q;
    logic [DATA_W-1:0] out_q;
    logic              edge_seen, active;

    assign edge_seen = strobe_s ^ strobe_d1_q;
    assign active    = (state_q != XS_WARMUP);
    assign rx_we     = active && edge_seen && !dir_s;
    assign tx_fetch  = active && edge_seen && dir_s;
    assign rx_waddr  = addr_s;
    assign rx_wdata  = data_s;
    assign tx_raddr  = addr_s;

    always_comb begin
        state_d = state_q;
        if (state_q == XS_WARMUP) begin
            if (warm_q == CNT_W'(WARM - 1))
                state_d = dir_s ? XS_OUTBOUND : XS_INBOUND;
        end else begin
            state_d = dir_s ? XS_OUTBOUND : XS_INBOUND;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= XS_WARMUP;
            warm_q      <= '0;
            strobe_d1_q <= 1'b0;
            out_q       <= '0;
        end else begin
            state_q     <= state_d;
            strobe_d1_q <= strobe_s;
            if (state_q == XS_WARMUP) warm_q <= warm_q + 1'b1;
            if (tx_fetch) out_q <= tx_rdata;
        end
    end

    assign out_data = out_q;
    assign out_en   = (state_q == XS_OUTBOUND);
endmodule

// File: rtl/strobe_xfer_ctrl.sv
module strobe_xfer_ctrl
    import xfer_pkg::*;
#(
    parameter int unsigned DATA_W      = XFER_DATA_W,
    parameter int unsigned ADDR_W      = XFER_ADDR_W,
    parameter int unsigned SYNC_STAGES = XFER_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_dir,
    input  logic              ext_strobe,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [DATA_W-1:0] ext_data_in,
    output logic [DATA_W-1:0] ext_data_out,
    output logic              ext_data_oe,
    input  logic              tx_wr_en,
    input  logic [ADDR_W-1:0] tx_wr_addr,
    input  logic [DATA_W-1:0] tx_wr_data,
    input  logic [ADDR_W-1:0] rx_rd_addr,
    output logic [DATA_W-1:0] rx_rd_data
);
    localparam int unsigned PIN_W = 2 + ADDR_W + DATA_W;

    logic [PIN_W-1:0]  pins_raw, pins_s;
    logic              dir_s, strobe_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              rx_we, tx_fetch;
    logic [ADDR_W-1:0] rx_waddr, tx_raddr;
    logic [DATA_W-1:0] rx_wdata, tx_rdata;

    // All pins share one pipeline so that address, data and strobe stay aligned.
    assign pins_raw = {ext_dir, ext_strobe, ext_addr, ext_data_in};

    xfer_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .d (pins_raw), .q (pins_s)
    );

    assign {dir_s, strobe_s, addr_s, data_s} = pins_s;

    xfer_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .dir_s    (dir_s),
        .strobe_s (strobe_s),
        .addr_s   (addr_s),
        .data_s   (data_s),
        .rx_we    (rx_we),
        .rx_waddr (rx_waddr),
        .rx_wdata (rx_wdata),
        .tx_fetch (tx_fetch),
        .tx_raddr (tx_raddr),
        .tx_rdata (tx_rdata),
        .out_data (ext_data_out),
        .out_en   (ext_data_oe)
    );

    xfer_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rx_bank (
        .clk (clk), .rst (rst),
        .we (rx_we), .waddr (rx_waddr), .wdata (rx_wdata),
        .raddr (rx_rd_addr), .rdata (rx_rd_data)
    );

    xfer_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_tx_bank (
        .clk (clk), .rst (rst),
        .we (tx_wr_en), .waddr (tx_wr_addr), .wdata (tx_wr_data),
        .raddr (tx_raddr), .rdata (tx_rdata)
    );
endmodule

// File: rtl/xfer_ctrl_chk.sv
module xfer_ctrl_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ext_dir,
    input logic              ext_strobe,
    input logic              ext_data_oe,
    input logic [DATA_W-1:0] ext_data_out,
    input logic              rx_we,
    input logic              tx_fetch
);
    AST_RESET_NO_DRIVE: assert property (@(posedge clk)
        rst |=> !ext_data_oe); // R1

    AST_OE_RISE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_data_oe) |-> $past(ext_dir, 3)); // R2

    AST_OE_FALL_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_data_oe) |-> !$past(ext_dir, 3)); // R2

    AST_RX_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        rx_we |-> ($past(ext_strobe, 2) != $past(ext_strobe, 3))); // R3

    AST_TX_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        tx_fetch |-> ($past(ext_strobe, 2) != $past(ext_strobe, 3))); // R4

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tx_fetch |=> $stable(ext_data_out)); // R5

    AST_RX_DIR_LOW: assert property (@(posedge clk) disable iff (rst)
        rx_we |-> !$past(ext_dir, 2)); // R6

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        !(rx_we && tx_fetch)); // R6
endmodule

bind strobe_xfer_ctrl xfer_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ext_dir      (ext_dir),
    .ext_strobe   (ext_strobe),
    .ext_data_oe  (ext_data_oe),
    .ext_data_out (ext_data_out),
    .rx_we        (rx_we),
    .tx_fetch     (tx_fetch)
);

// File: tb/strobe_xfer_ctrl_test.sv
module strobe_xfer_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_dir = 1'b0;
    logic        ext_strobe = 1'b0;
    logic [4:0]  ext_addr = '0;
    logic [15:0] ext_data_in = '0;
    logic [15:0] ext_data_out;
    logic        ext_data_oe;
    logic        tx_wr_en = 1'b0;
    logic [4:0]  tx_wr_addr = '0;
    logic [15:0] tx_wr_data = '0;
    logic [4:0]  rx_rd_addr = '0;
    logic [15:0] rx_rd_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_xfer_ctrl uut (
        .clk (clk), .rst (rst),
        .ext_dir (ext_dir), .ext_strobe (ext_strobe),
        .ext_addr (ext_addr), .ext_data_in (ext_data_in),
        .ext_data_out (ext_data_out), .ext_data_oe (ext_data_oe),
        .tx_wr_en (tx_wr_en), .tx_wr_addr (tx_wr_addr), .tx_wr_data (tx_wr_data),
        .rx_rd_addr (rx_rd_addr), .rx_rd_data (rx_rd_data)
    );

    function automatic logic [15:0] pat_in(input int a);
        return 16'((a * 16'h0923) ^ 16'h5A3C);
    endfunction

    function automatic logic [15:0] pat_out(input int a);
        return 16'((a * 16'h1D07) ^ 16'hC3A1);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rx_read(input int a, output logic [15:0] v);
        rx_rd_addr = 5'(a);
        #1;
        v = rx_rd_data;
    endtask

    // One strobe edge with address and data presented together; transfer lands at the third clock edge.
    task automatic strobe_edge(input int a, input logic [15:0] d);
        @(negedge clk);
        ext_addr    = 5'(a);
        ext_data_in = d;
        ext_strobe  = ~ext_strobe;
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 oe after reset", 16'(ext_data_oe), 16'h0);
        check("R1 out after reset", ext_data_out, 16'h0);
        for (int a = 0; a < 32; a++) begin
            rx_read(a, v);
            check("R1 rx cleared", v, 16'h0);
        end
        repeat (4) @(negedge clk);

        // R3: inbound sweep, alternating strobe polarity
        for (int a = 0; a < 32; a++) begin
            strobe_edge(a, pat_in(a));
            rx_read(a, v);
            check("R3 inbound store", v, pat_in(a));
        end
        // R6: inbound traffic leaves the pin output untouched
        check("R6 out after inbound", ext_data_out, 16'h0);

        // R5: address and data change with strobe still
        @(negedge clk);
        ext_addr = 5'd3;
        ext_data_in = 16'hFFFF;
        repeat (8) @(negedge clk);
        rx_read(3, v);
        check("R5 no edge no store", v, pat_in(3));

        // R8: fill transmit bank
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            tx_wr_en = 1'b1; tx_wr_addr = 5'(a); tx_wr_data = pat_out(a);
        end
        @(negedge clk);
        tx_wr_en = 1'b0;

        // R2: enable rises at the third clock edge
        @(negedge clk);
        ext_dir = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R2 oe still low after 2 edges", 16'(ext_data_oe), 16'h0);
        @(negedge clk);
        check("R2 oe high after 3 edges", 16'(ext_data_oe), 16'h1);
        repeat (3) @(negedge clk);

        // R4: outbound sweep, descending addresses
        for (int a = 31; a >= 0; a--) begin
            strobe_edge(a, 16'hDEAD);
            check("R4 outbound word", ext_data_out, pat_out(a));
            check("R4 oe during outbound", 16'(ext_data_oe), 16'h1);
        end

        // R6: outbound traffic leaves receive bank intact
        for (int a = 0; a < 32; a++) begin
            rx_read(a, v);
            check("R6 rx kept through outbound", v, pat_in(a));
        end

        // R5: transmit rewrite with no edge keeps the pins steady
        @(negedge clk);
        tx_wr_en = 1'b1; tx_wr_addr = 5'd0; tx_wr_data = 16'h7E81;
        @(negedge clk);
        tx_wr_en = 1'b0;
        repeat (6) @(negedge clk);
        check("R5 out held without edge", ext_data_out, pat_out(0));
        // R8: new word appears on the next edge
        strobe_edge(0, 16'h0000);
        check("R8 rewritten tx word", ext_data_out, 16'h7E81);

        // R2: enable falls at the third clock edge
        @(negedge clk);
        ext_dir = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R2 oe still high after 2 edges", 16'(ext_data_oe), 16'h1);
        @(negedge clk);
        check("R2 oe low after 3 edges", 16'(ext_data_oe), 16'h0);

        // R7: strobe high at reset release
        @(negedge clk);
        rst = 1'b1;
        ext_strobe = 1'b0;
        ext_addr = 5'd9;
        ext_data_in = 16'h1234;
        repeat (3) @(negedge clk);
        ext_strobe = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        rx_read(9, v);
        check("R7 no spurious transfer", v, 16'h0);
        check("R7 oe low after reset", 16'(ext_data_oe), 16'h0);
        strobe_edge(9, 16'h1234);
        rx_read(9, v);
        check("R7 first real edge stores", v, 16'h1234);
        rx_read(10, v);
        check("R7 neighbour untouched", v, 16'h0);

        finish_run();
    end
endmodule